// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host front end of a three-channel interval timer. A host reaches it through a chip select, separate active-low read and write strobes, two address bits and an 8-bit data bus. Writes to the control address configure a channel or freeze that channel's count. Writes to a channel address deliver the count bytes, which the block assembles into a 16-bit load value according to the channel's access setting. Reads from a channel address return either the live count or a frozen snapshot, one byte per read.

The counters are separate blocks. Each channel's running 16-bit count comes in on `count_in`. The block gives back, per channel, its stored configuration, a one-cycle pulse when a new configuration is written, a one-cycle pulse when only the first byte of a two-byte load has arrived, and a one-cycle pulse with the completed 16-bit value. The bus is synchronous to `clk`. Every clock cycle in which `cs_n` is low and exactly one of `rd_n` or `wr_n` is low counts as one access. Read data is valid in that same cycle.

Top module: `tmr_host_if`

## Requirements
- R1: An access happens in a cycle only when `cs_n` is 0 and exactly one of `rd_n`/`wr_n` is 0. Address 0, 1 or 2 selects channel 0, 1 or 2, and address 3 selects the control word. Cycles with `cs_n` high, or with both strobes low, change no state and produce no pulses.
- R2: A control word to address 3 has channel select in bits 7:6, access code in bits 5:4, counting mode in bits 3:1 and BCD flag in bit 0. If the access code is nonzero, the word stores access code, mode and BCD flag for that channel and raises its mode-set pulse in the next cycle. It also returns both byte pointers to the low byte and drops any held snapshot. Mode codes 6 and 7 are stored as 2 and 3.
- R3: A control word with channel select 3 changes nothing.
- R4: With access code 01 (low only), each channel write gives a load pulse in the next cycle, with value {8'h00, byte}.
- R5: With access code 10 (high only), each channel write gives a load pulse with value {byte, 8'h00}.
- R6: With access code 11 (low then high), the first write gives only a first-byte pulse. The second write gives a load pulse with value {second byte, first byte}.
- R7: Without a snapshot, a read returns a byte of the live count. Under code 11 reads alternate low then high. Code 01 always returns the low byte and code 10 always the high byte.
- R8: A control word with access code 00 (latch) captures the channel's live count that cycle. It leaves the configuration unchanged and raises no mode-set pulse. Later reads return the snapshot even as the live count moves.
- R9: A snapshot is held until the read of its last byte in the channel's byte order: two reads under code 11, one under code 01 or 10. Latch commands while a snapshot is held are ignored.
- R10: Reads never raise load, first-byte or mode-set pulses. `rdata` is 0 in any cycle that is not a channel read, including reads of address 3.
- R11: After reset every channel has access code 01, mode 0 and binary counting. Byte pointers are at the low byte, no snapshot is held and no pulses are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: channels 0 to 2, control at 3 |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid in the read cycle |
| count_in | input | 48 | Live 16-bit counts, channel i at bits 16i+15:16i |
| first_stb | output | 3 | Per channel: first byte of a two-byte load written |
| load_stb | output | 3 | Per channel: new count complete |
| load_val | output | 48 | Per channel completed count, channel i at bits 16i+15:16i |
| mset_stb | output | 3 | Per channel: configuration written |
| cfg_acc | output | 6 | Per channel access code, channel i at bits 2i+1:2i |
| cfg_mode | output | 9 | Per channel counting mode, channel i at bits 3i+2:3i |
| cfg_bcd | output | 3 | Per channel BCD flag |

## Verification
The assertions check on every cycle that at most one decoded access is active, and that pulses trace back to the access that caused them. They also check that a read never raises a load or first-byte pulse, that only two-byte access raises a first-byte pulse, and that a held snapshot stays frozen until a read or reconfiguration. Only the bench's scenarios can show byte order and value assembly across several writes, the snapshot content after the live count has moved, and the release point of a snapshot. The same holds for the pointer state surviving ignored cycles and for mode folding. These are compared cycle by cycle against a behavioural model and also checked with literal expected bytes.

// File: rtl/tmr_if_pkg.sv
// Package: shared types and helpers for the timer host register interface.
// Assumes a byte-wide control word with fields at fixed bit positions.
package tmr_if_pkg;

    // Access code carried in control word bits 5:4
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    // Stored per-channel configuration
    typedef struct packed {
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{acc: ACC_LO, mode: 3'd0, bcd: 1'b0};

    // Mode codes 6 and 7 alias modes 2 and 3
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
    endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
// Module: tmr_bus_decode
// Turns the host strobes, address and control-word fields into one-hot
// per-channel access requests. Purely combinational; at most one request
// is active per cycle. Assumes the control address is the top address code.
module tmr_bus_decode #(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2
) (
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cw_sel,
    input  logic [1:0]        cw_acc,
    output logic [NUM_CH-1:0] cfg_wr,
    output logic [NUM_CH-1:0] latch_cmd,
    output logic [NUM_CH-1:0] cnt_wr,
    output logic [NUM_CH-1:0] cnt_rd
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = '1;

    logic acc_ok;
    logic is_wr;
    logic is_rd;
    logic ctl_hit;

    // Qualify a single-strobe access under chip select
    always_comb begin
        acc_ok  = ~cs_n & (rd_n ^ wr_n);
        is_wr   = acc_ok & ~wr_n;
        is_rd   = acc_ok & ~rd_n;
        ctl_hit = (addr == CTL_ADDR);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // Per-channel request decode
        always_comb begin
            cnt_wr[i]    = is_wr & ~ctl_hit & (addr == ADDR_W'(i));
            cnt_rd[i]    = is_rd & ~ctl_hit & (addr == ADDR_W'(i));
            cfg_wr[i]    = is_wr & ctl_hit & (cw_sel == 2'(i)) & (cw_acc != 2'b00);
            latch_cmd[i] = is_wr & ctl_hit & (cw_sel == 2'(i)) & (cw_acc == 2'b00);
        end
    end

endmodule

// File: rtl/tmr_chan_regs.sv
// Module: tmr_chan_regs
// Holds one channel's configuration, its write byte sequencer, its read
// byte pointer and its count snapshot. Produces one-cycle registered
// pulses for mode set, first byte and completed load. Assumes at most one
// of its request inputs is high per cycle.
module tmr_chan_regs
    import tmr_if_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              latch_cmd,
    input  logic              cnt_wr,
    input  logic              cnt_rd,
    input  logic [5:0]        cw_field,
    input  logic [DATA_W-1:0] wbyte,
    input  logic [CNT_W-1:0]  count_in,
    output chan_cfg_t         cfg,
    output logic [DATA_W-1:0] rd_byte,
    output logic              first_stb,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic              mset_stb
);
    chan_cfg_t         cfg_q;
    logic              wr_hi_q;
    logic [DATA_W-1:0] lo_hold_q;
    logic              rd_hi_q;
    logic              latched_q;
    logic [CNT_W-1:0]  snap_q;
    logic [CNT_W-1:0]  rd_src;
    logic              take_hi;

    assign cfg = cfg_q;

    // Select the byte returned by a read of this channel
    always_comb begin
        rd_src  = latched_q ? snap_q : count_in;
        take_hi = (cfg_q.acc == ACC_HI) | ((cfg_q.acc == ACC_LOHI) & rd_hi_q);
        rd_byte = take_hi ? rd_src[CNT_W-1:DATA_W] : rd_src[DATA_W-1:0];
    end

    // Configuration, snapshot and byte-pointer state with output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= CFG_RESET;
            wr_hi_q   <= 1'b0;
            lo_hold_q <= '0;
            rd_hi_q   <= 1'b0;
            latched_q <= 1'b0;
            snap_q    <= '0;
            first_stb <= 1'b0;
            load_stb  <= 1'b0;
            load_val  <= '0;
            mset_stb  <= 1'b0;
        end else begin
            first_stb <= 1'b0;
            load_stb  <= 1'b0;
            mset_stb  <= 1'b0;
            if (cfg_wr) begin
                cfg_q.acc  <= acc_e'(cw_field[5:4]);
                cfg_q.mode <= fold_mode(cw_field[3:1]);
                cfg_q.bcd  <= cw_field[0];
                wr_hi_q    <= 1'b0;
                rd_hi_q    <= 1'b0;
                latched_q  <= 1'b0;
                mset_stb   <= 1'b1;
            end else if (latch_cmd) begin
                if (!latched_q) begin
                    latched_q <= 1'b1;
                    snap_q    <= count_in;
                end
            end else if (cnt_wr) begin
                unique case (cfg_q.acc)
                    ACC_LO: begin
                        load_stb <= 1'b1;
                        load_val <= {{DATA_W{1'b0}}, wbyte};
                    end
                    ACC_HI: begin
                        load_stb <= 1'b1;
                        load_val <= {wbyte, {DATA_W{1'b0}}};
                    end
                    ACC_LOHI: begin
                        if (!wr_hi_q) begin
                            lo_hold_q <= wbyte;
                            wr_hi_q   <= 1'b1;
                            first_stb <= 1'b1;
                        end else begin
                            load_stb <= 1'b1;
                            load_val <= {wbyte, lo_hold_q};
                            wr_hi_q  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end else if (cnt_rd) begin
                if (cfg_q.acc == ACC_LOHI) begin
                    rd_hi_q <= ~rd_hi_q;
                    if (rd_hi_q) latched_q <= 1'b0;
                end else begin
                    latched_q <= 1'b0;
                end
            end
        end
    end

    AST_MSET_FROM_CW: assert property (@(posedge clk) disable iff (!rst_n)
        mset_stb |-> $past(cfg_wr)); // R2
    AST_LOAD_FROM_WR: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> $past(cnt_wr)); // R4
    AST_FIRST_ONLY_LOHI: assert property (@(posedge clk) disable iff (!rst_n)
        first_stb |-> (cfg_q.acc == ACC_LOHI && wr_hi_q)); // R6
    AST_READ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd |=> (!load_stb && !first_stb && !mset_stb)); // R10
    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_q && !cnt_rd && !cfg_wr) |=> (latched_q && $stable(snap_q))); // R9

endmodule

// File: rtl/tmr_rd_mux.sv
// Module: tmr_rd_mux
// Returns the byte of the channel being read, or zero when no channel read
// is active. Assumes the select vector is one-hot or zero.
module tmr_rd_mux #(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 8
) (
    input  logic [NUM_CH-1:0]        rd_sel,
    input  logic [NUM_CH*DATA_W-1:0] ch_bytes,
    output logic [DATA_W-1:0]        rdata
);
    // AND-OR merge of the selected channel byte
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            rdata = rdata | (ch_bytes[i*DATA_W +: DATA_W] & {DATA_W{rd_sel[i]}});
        end
    end

endmodule

// File: rtl/tmr_host_if.sv
// Module: tmr_host_if
// Host register front end of a three-channel interval timer: decodes the
// byte bus, keeps per-channel configuration and byte sequencing, and
// serves live or frozen counts. Assumes a synchronous bus where each cycle
// with chip select and one strobe low is one access.
module tmr_host_if
    import tmr_if_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [NUM_CH*CNT_W-1:0]  count_in,
    output logic [NUM_CH-1:0]        first_stb,
    output logic [NUM_CH-1:0]        load_stb,
    output logic [NUM_CH*CNT_W-1:0]  load_val,
    output logic [NUM_CH-1:0]        mset_stb,
    output logic [NUM_CH*2-1:0]      cfg_acc,
    output logic [NUM_CH*3-1:0]      cfg_mode,
    output logic [NUM_CH-1:0]        cfg_bcd
);
    logic [NUM_CH-1:0]        cfg_wr;
    logic [NUM_CH-1:0]        latch_cmd;
    logic [NUM_CH-1:0]        cnt_wr;
    logic [NUM_CH-1:0]        cnt_rd;
    logic [NUM_CH*DATA_W-1:0] ch_bytes;

    tmr_bus_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .cw_sel    (wdata[7:6]),
        .cw_acc    (wdata[5:4]),
        .cfg_wr    (cfg_wr),
        .latch_cmd (latch_cmd),
        .cnt_wr    (cnt_wr),
        .cnt_rd    (cnt_rd)
    );

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_wr, latch_cmd, cnt_wr, cnt_rd})); // R1

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        chan_cfg_t cfg_i;

        tmr_chan_regs #(
            .DATA_W (DATA_W),
            .CNT_W  (CNT_W)
        ) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_wr    (cfg_wr[i]),
            .latch_cmd (latch_cmd[i]),
            .cnt_wr    (cnt_wr[i]),
            .cnt_rd    (cnt_rd[i]),
            .cw_field  (wdata[5:0]),
            .wbyte     (wdata),
            .count_in  (count_in[i*CNT_W +: CNT_W]),
            .cfg       (cfg_i),
            .rd_byte   (ch_bytes[i*DATA_W +: DATA_W]),
            .first_stb (first_stb[i]),
            .load_stb  (load_stb[i]),
            .load_val  (load_val[i*CNT_W +: CNT_W]),
            .mset_stb  (mset_stb[i])
        );

        // Flatten the channel configuration onto the output buses
        always_comb begin
            cfg_acc[i*2 +: 2]  = cfg_i.acc;
            cfg_mode[i*3 +: 3] = cfg_i.mode;
            cfg_bcd[i]         = cfg_i.bcd;
        end
    end

    tmr_rd_mux #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) i_rd_mux (
        .rd_sel   (cnt_rd),
        .ch_bytes (ch_bytes),
        .rdata    (rdata)
    );

endmodule

// File: tb/test_tmr_host_if.sv
// Bench for tmr_host_if: a behavioural model updated on each rising edge,
// compared with every output on each falling edge, plus directed scenarios
// with literal expected values.
module test_tmr_host_if;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, rd_n, wr_n;
    logic [1:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [47:0] cnt_live;
    logic [2:0]  first_stb, load_stb, mset_stb, cfg_bcd;
    logic [47:0] load_val;
    logic [5:0]  cfg_acc;
    logic [8:0]  cfg_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 0;

    always #10 clk = ~clk;

    tmr_host_if i_tmr_host_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .count_in(cnt_live),
        .first_stb(first_stb), .load_stb(load_stb), .load_val(load_val),
        .mset_stb(mset_stb), .cfg_acc(cfg_acc), .cfg_mode(cfg_mode),
        .cfg_bcd(cfg_bcd)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_acc[3], m_mode[3], m_bcd[3], m_whi[3], m_lo[3], m_rhi[3], m_lat[3];
    int m_snap[3], m_lval[3], m_first[3], m_load[3], m_mset[3];

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            m_first[i] = 0; m_load[i] = 0; m_mset[i] = 0;
        end
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_acc[i] = 1; m_mode[i] = 0; m_bcd[i] = 0; m_whi[i] = 0;
                m_lo[i] = 0; m_rhi[i] = 0; m_lat[i] = 0; m_snap[i] = 0; m_lval[i] = 0;
            end
        end else if (!cs_n && (rd_n != wr_n)) begin
            if (!wr_n) begin
                if (addr == 2'd3) begin
                    int s;
                    s = int'(wdata[7:6]);
                    if (s != 3) begin
                        if (wdata[5:4] == 2'b00) begin
                            if (m_lat[s] == 0) begin
                                m_lat[s] = 1;
                                m_snap[s] = int'(cnt_live[s*16 +: 16]);
                            end
                        end else begin
                            int md;
                            md = int'(wdata[3:1]);
                            if (md >= 6) md = md - 4;
                            m_acc[s] = int'(wdata[5:4]); m_mode[s] = md; m_bcd[s] = int'(wdata[0]);
                            m_whi[s] = 0; m_rhi[s] = 0; m_lat[s] = 0; m_mset[s] = 1;
                        end
                    end
                end else begin
                    int c;
                    c = int'(addr);
                    if (m_acc[c] == 1) begin
                        m_load[c] = 1; m_lval[c] = int'(wdata);
                    end else if (m_acc[c] == 2) begin
                        m_load[c] = 1; m_lval[c] = int'(wdata) * 256;
                    end else if (m_whi[c] == 0) begin
                        m_lo[c] = int'(wdata); m_whi[c] = 1; m_first[c] = 1;
                    end else begin
                        m_load[c] = 1; m_lval[c] = int'(wdata) * 256 + m_lo[c]; m_whi[c] = 0;
                    end
                end
            end else if (addr != 2'd3) begin
                int c;
                c = int'(addr);
                if (m_acc[c] == 3) begin
                    if (m_lat[c] != 0 && m_rhi[c] != 0) m_lat[c] = 0;
                    m_rhi[c] = 1 - m_rhi[c];
                end else begin
                    m_lat[c] = 0;
                end
            end
        end
        started = 1;
    end

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (started) begin
            int exp_rd;
            exp_rd = 0;
            if (!cs_n && !rd_n && wr_n && addr != 2'd3) begin
                int c, src;
                bit hi;
                c = int'(addr);
                src = (m_lat[c] != 0) ? m_snap[c] : int'(cnt_live[c*16 +: 16]);
                hi = (m_acc[c] == 2) || (m_acc[c] == 3 && m_rhi[c] != 0);
                exp_rd = hi ? (src / 256) % 256 : src % 256;
            end
            chk("R7 model rdata", 64'(rdata), 64'(exp_rd));
            for (int i = 0; i < 3; i++) begin
                chk("R6 model first_stb", 64'(first_stb[i]), 64'(m_first[i]));
                chk("R4 model load_stb", 64'(load_stb[i]), 64'(m_load[i]));
                chk("R5 model load_val", 64'(load_val[i*16 +: 16]), 64'(m_lval[i]));
                chk("R2 model mset_stb", 64'(mset_stb[i]), 64'(m_mset[i]));
                chk("R2 model cfg", 64'({cfg_acc[i*2 +: 2], cfg_mode[i*3 +: 3], cfg_bcd[i]}),
                    64'(m_acc[i] * 16 + m_mode[i] * 2 + m_bcd[i]));
            end
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        cs_n = 0; wr_n = 0; rd_n = 1; addr = a; wdata = d;
        @(posedge clk); #2;
        cs_n = 1; wr_n = 1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #2;
        cs_n = 0; rd_n = 0; wr_n = 1; addr = a;
        #6 d = rdata;
        @(posedge clk); #2;
        cs_n = 1; rd_n = 1;
    endtask

    task automatic bus_raw(input logic c, input logic r, input logic w,
                           input logic [1:0] a, input logic [7:0] d, output logic [7:0] q);
        @(posedge clk); #2;
        cs_n = c; rd_n = r; wr_n = w; addr = a; wdata = d;
        #6 q = rdata;
        @(posedge clk); #2;
        cs_n = 1; rd_n = 1; wr_n = 1;
    endtask

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [17:0] cfg_snap;
        rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; wdata = 0; cnt_live = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R11 reset state
        chk("R11 cfg_acc", 64'(cfg_acc), 64'(6'b010101));
        chk("R11 cfg_mode", 64'(cfg_mode), 64'(0));
        chk("R11 pulses", 64'({first_stb, load_stb, mset_stb}), 64'(0));

        // R2 configure ch0 two-byte, mode 2
        bus_wr(2'd3, 8'h34);
        chk("R2 mset ch0", 64'(mset_stb), 64'(3'b001));
        chk("R2 cfg ch0", 64'({cfg_acc[1:0], cfg_mode[2:0]}), 64'({2'b11, 3'd2}));
        // R6 two-byte load
        bus_wr(2'd0, 8'h34);
        chk("R6 first only", 64'({first_stb, load_stb}), 64'({3'b001, 3'b000}));
        bus_wr(2'd0, 8'h12);
        chk("R6 load pulse", 64'({first_stb, load_stb}), 64'({3'b000, 3'b001}));
        chk("R6 load value", 64'(load_val[15:0]), 64'(16'h1234));
        // R4 low only on ch1
        bus_wr(2'd3, 8'h56);
        bus_wr(2'd1, 8'hAB);
        chk("R4 load value", 64'(load_val[31:16]), 64'(16'h00AB));
        // R2 mode folding, R5 high only on ch2
        bus_wr(2'd3, 8'hAF);
        chk("R2 folded mode", 64'(cfg_mode[8:6]), 64'(3'd3));
        chk("R2 bcd flag", 64'(cfg_bcd[2]), 64'(1));
        bus_wr(2'd2, 8'h20);
        chk("R5 load value", 64'(load_val[47:32]), 64'(16'h2000));
        // R3 select 3 ignored
        cfg_snap = {cfg_acc, cfg_mode, cfg_bcd};
        bus_wr(2'd3, 8'hF4);
        chk("R3 cfg unchanged", 64'({cfg_acc, cfg_mode, cfg_bcd}), 64'(cfg_snap));
        chk("R3 no mset", 64'(mset_stb), 64'(0));

        // R7 live reads
        cnt_live = {16'hC3D4, 16'h5A6B, 16'hBEEF};
        bus_rd(2'd0, b); chk("R7 ch0 low", 64'(b), 64'(8'hEF));
        bus_rd(2'd0, b); chk("R7 ch0 high", 64'(b), 64'(8'hBE));
        bus_rd(2'd1, b); chk("R7 ch1 low", 64'(b), 64'(8'h6B));
        bus_rd(2'd1, b); chk("R7 ch1 low again", 64'(b), 64'(8'h6B));
        bus_rd(2'd2, b); chk("R7 ch2 high", 64'(b), 64'(8'hC3));

        // R8 latch on ch0
        cfg_snap = {cfg_acc, cfg_mode, cfg_bcd};
        bus_wr(2'd3, 8'h00);
        chk("R8 cfg unchanged", 64'({cfg_acc, cfg_mode, cfg_bcd}), 64'(cfg_snap));
        chk("R8 no mset", 64'(mset_stb), 64'(0));
        cnt_live[15:0] = 16'h1111;
        bus_rd(2'd0, b); chk("R8 snapshot low", 64'(b), 64'(8'hEF));
        // R9 second latch ignored, release after high byte
        bus_wr(2'd3, 8'h00);
        cnt_live[15:0] = 16'h2222;
        bus_rd(2'd0, b); chk("R9 snapshot high", 64'(b), 64'(8'hBE));
        cnt_live[15:0] = 16'h2233;
        bus_rd(2'd0, b); chk("R9 live after release", 64'(b), 64'(8'h33));
        // R9 single-byte release on ch1
        bus_wr(2'd3, 8'h40);
        cnt_live[31:16] = 16'h0102;
        bus_rd(2'd1, b); chk("R9 ch1 snapshot", 64'(b), 64'(8'h6B));
        bus_rd(2'd1, b); chk("R9 ch1 released", 64'(b), 64'(8'h02));

        // R2 mode set drops snapshot and resets pointers
        bus_wr(2'd3, 8'h00);
        cnt_live[15:0] = 16'h4433;
        bus_wr(2'd3, 8'h34);
        bus_rd(2'd0, b); chk("R2 snapshot dropped", 64'(b), 64'(8'h33));

        // R1 ignored cycles keep pointers
        bus_raw(1'b1, 1'b1, 1'b0, 2'd0, 8'h99, b);
        chk("R1 cs high no pulse", 64'({first_stb, load_stb}), 64'(0));
        bus_raw(1'b0, 1'b0, 1'b0, 2'd0, 8'h99, b);
        chk("R1 both low rdata", 64'(b), 64'(0));
        chk("R1 both low no pulse", 64'({first_stb, load_stb}), 64'(0));
        bus_rd(2'd0, b); chk("R1 read pointer kept", 64'(b), 64'(8'h44));
        bus_wr(2'd0, 8'h77);
        chk("R1 write pointer kept", 64'({first_stb, load_stb}), 64'({3'b001, 3'b000}));
        // R10 control read returns zero, read gives no pulse
        bus_rd(2'd3, b); chk("R10 control read", 64'(b), 64'(0));
        bus_rd(2'd0, b);
        chk("R10 no pulse after read", 64'({first_stb, load_stb, mset_stb}), 64'(0));
        bus_wr(2'd0, 8'h66);
        chk("R6 resumed load", 64'(load_val[15:0]), 64'(16'h6677));

        repeat (4) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule